// File: doc/BRIEF.md
# Automatic Thermal Sensor Poll Controller

This block watches several on-die temperature sensors without software help. Once it is armed, it picks the enabled sensor channels in turn. For each one it asks an external converter for a 12-bit reading, stores the result and compares it against two per-channel limits. The converter's code falls as the die warms, so a reading below a limit means "too hot". The lower limit class raises an alarm interrupt. The other class trips a hardware shutdown.

A noise filter guards each limit. A run of consecutive hot samples, set by a register, must occur before the alarm or the shutdown acts. Any cool sample restarts the run. The shutdown is latched and can be routed to a reset-controller pin, to a GPIO/power-IC pin, or to both, with a programmable active level. The controller waits a long interval between conversions while everything is cool and a short interval while any channel is hot. Software programs it through a simple register port.

Top module: `thermal_poll_ctrl`

## Requirements
- R1: After reset, control reads 0, both filter counts read 10, the cool interval reads 1000, the hot interval reads 100, the interrupt is low, and both shutdown pins sit at their inactive level, which is high for the active-low default.
- R2: A channel is polled if any of bits ch, 4+ch or 8+ch of the enable register (0x08) is set. Polled channels are served in ascending round-robin order, one conversion at a time. The start request is a one-cycle pulse on that channel's line only.
- R3: The data register of a channel (0x20+4·ch) takes the 12-bit converter result when that channel's done pulse arrives for an outstanding request.
- R4: The start pulse of the next conversion rises a set number of clock edges after the edge that captured the previous result. That number is the cool interval (0x68) if no channel's latest sample lies below either of its limits, and the hot interval (0x6C) otherwise.
- R5: A sample is over the alarm limit when it is strictly smaller than the channel's alarm compare value (0x30+4·ch). Pending bit ch of 0x0C sets on a sample that brings the count of consecutive over-limit samples to at least the alarm filter count (0x60). A sample that is not over the limit clears that count.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. The interrupt output is high exactly when a pending bit is set and bit ch of 0x08 is also set.
- R7: The shutdown compare value (0x40+4·ch) and the shutdown filter count (0x64) work the same way as the alarm pair. When the shutdown qualifies, the GPIO-side pin latches if bit 4+ch of 0x08 is set, and the reset-side pin latches if bit 8+ch is set. Each latch holds until reset.
- R8: Bit 8 of control (0x04) sets the pin level. With 1 an active shutdown drives the pin high. With 0 it drives the pin low, and the inactive level is the opposite.
- R9: Bit 0 of control arms polling. While it is 0, no start pulse is issued, and the data registers and pending bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| adc_start | output | NCH | Per-channel conversion request pulse |
| adc_done | input | NCH | Per-channel conversion complete pulse |
| adc_data | input | NCH*12 | Per-channel result, channel ch at bits 12·ch upward |
| irq | output | 1 | Alarm interrupt |
| shut_rst | output | 1 | Shutdown toward the reset controller |
| shut_gpio | output | 1 | Shutdown toward the GPIO/power-IC pin |

## Verification
The hardest state to reach is a filter count that sits one sample short of its limit on one channel while other channels are interleaved between its samples. A hot-period gap must also follow a hot sample from a different channel. The bench keeps a sample-by-sample model of every channel's counters, hot flags and round-robin pointer. It feeds a seeded random run of readings scattered tightly around the alarm limit, with random pending clears in between. Directed sequences then force a count that is broken by one cool sample, a routed-only channel with its interrupt masked, a stopped controller, and a latched shutdown under both pin polarities.

// File: rtl/thermal_poll_ctrl.sv
module thermal_poll_ctrl #(
  parameter int NCH          = 3,
  parameter int DW           = 12,
  parameter int DBW          = 8,
  parameter int TW           = 16,
  parameter int DEB_RST      = 10,
  parameter int PER_COOL_RST = 1000,
  parameter int PER_HOT_RST  = 100
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    adc_start,
  input  logic [NCH-1:0]    adc_done,
  input  logic [NCH*DW-1:0] adc_data,
  output logic              irq,
  output logic              shut_rst,
  output logic              shut_gpio
);
  // NCH may be at most 4: the enable register packs three 4-bit groups
  localparam int CW = NCH > 1 ? $clog2(NCH) : 1;
  localparam logic [DBW-1:0] CMAX = '1;
  localparam logic [7:0] A_CTRL = 8'h04, A_IEN = 8'h08, A_PEND = 8'h0C, A_DATA = 8'h20,
                         A_ALC = 8'h30, A_SHC = 8'h40, A_ADEB = 8'h60, A_SDEB = 8'h64,
                         A_PCOOL = 8'h68, A_PHOT = 8'h6C;

  logic           run, pol, busy, sh_g, sh_r;
  logic [NCH-1:0] en_irq, en_g, en_r, pend, hot;
  logic [DW-1:0]  dat [NCH];
  logic [DW-1:0]  alc [NCH];
  logic [DW-1:0]  shc [NCH];
  logic [DBW-1:0] acnt [NCH];
  logic [DBW-1:0] scnt [NCH];
  logic [DBW-1:0] adeb, sdeb;
  logic [TW-1:0]  per_c, per_h, tmr;
  logic [CW-1:0]  cur, last, nxt;
  logic           any_en;

  wire [NCH-1:0] ch_en   = en_irq | en_g | en_r;
  wire [TW-1:0]  per_now = |hot ? per_h : per_c;
  wire [TW:0]    tmr_p1  = {1'b0, tmr} + {{TW{1'b0}}, 1'b1};
  wire           fire    = run && !busy && any_en && (tmr_p1 >= {1'b0, per_now});
  wire           take    = run && busy && adc_done[cur];
  wire [DW-1:0]  smp     = adc_data[int'(cur)*DW +: DW];
  wire           a_over  = smp < alc[cur];
  wire           s_over  = smp < shc[cur];
  wire [DBW-1:0] a_nx    = (acnt[cur] == CMAX) ? CMAX : acnt[cur] + 1'b1;
  wire [DBW-1:0] s_nx    = (scnt[cur] == CMAX) ? CMAX : scnt[cur] + 1'b1;

  assign irq       = |(pend & en_irq);
  assign shut_gpio = pol ? sh_g : ~sh_g;
  assign shut_rst  = pol ? sh_r : ~sh_r;

  always_comb begin
    nxt    = last;
    any_en = 1'b0;
    for (int i = NCH; i >= 1; i--) begin
      if (ch_en[(int'(last) + i) % NCH]) begin
        nxt    = CW'((int'(last) + i) % NCH);
        any_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; pol <= 1'b0; busy <= 1'b0; sh_g <= 1'b0; sh_r <= 1'b0;
      en_irq <= '0; en_g <= '0; en_r <= '0; pend <= '0; hot <= '0;
      adeb <= DBW'(DEB_RST); sdeb <= DBW'(DEB_RST);
      per_c <= TW'(PER_COOL_RST); per_h <= TW'(PER_HOT_RST);
      tmr <= '0; cur <= '0; last <= CW'(NCH - 1); adc_start <= '0;
      for (int c = 0; c < NCH; c++) begin
        dat[c] <= '0; alc[c] <= '0; shc[c] <= '0; acnt[c] <= '0; scnt[c] <= '0;
      end
    end else begin
      adc_start <= '0;
      if (bus_we) begin
        case (bus_addr)
          A_CTRL:  begin run <= bus_wdata[0]; pol <= bus_wdata[8]; end
          A_IEN:   for (int c = 0; c < NCH; c++) begin
                     en_irq[c] <= bus_wdata[c];
                     en_g[c]   <= bus_wdata[4+c];
                     en_r[c]   <= bus_wdata[8+c];
                   end
          A_PEND:  pend  <= pend & ~bus_wdata[NCH-1:0];
          A_ADEB:  adeb  <= bus_wdata[DBW-1:0];
          A_SDEB:  sdeb  <= bus_wdata[DBW-1:0];
          A_PCOOL: per_c <= bus_wdata[TW-1:0];
          A_PHOT:  per_h <= bus_wdata[TW-1:0];
          default: ;
        endcase
        for (int c = 0; c < NCH; c++) begin
          if (bus_addr == A_ALC + 8'(4*c)) alc[c] <= bus_wdata[DW-1:0];
          if (bus_addr == A_SHC + 8'(4*c)) shc[c] <= bus_wdata[DW-1:0];
        end
      end
      if (!run) begin
        busy <= 1'b0;
        tmr  <= '0;
      end else if (fire) begin
        adc_start[nxt] <= 1'b1;
        busy <= 1'b1;
        cur  <= nxt;
        last <= nxt;
        tmr  <= '0;
      end else if (take) begin
        busy      <= 1'b0;
        tmr       <= '0;
        dat[cur]  <= smp;
        hot[cur]  <= a_over | s_over;
        acnt[cur] <= a_over ? a_nx : '0;
        scnt[cur] <= s_over ? s_nx : '0;
        if (a_over && a_nx >= adeb) pend[cur] <= 1'b1;
        if (s_over && s_nx >= sdeb) begin
          if (en_g[cur]) sh_g <= 1'b1;
          if (en_r[cur]) sh_r <= 1'b1;
        end
      end else if (!busy && tmr != '1) begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  begin bus_rdata[0] = run; bus_rdata[8] = pol; end
      A_IEN:   for (int c = 0; c < NCH; c++) begin
                 bus_rdata[c]   = en_irq[c];
                 bus_rdata[4+c] = en_g[c];
                 bus_rdata[8+c] = en_r[c];
               end
      A_PEND:  bus_rdata[NCH-1:0] = pend;
      A_ADEB:  bus_rdata[DBW-1:0] = adeb;
      A_SDEB:  bus_rdata[DBW-1:0] = sdeb;
      A_PCOOL: bus_rdata[TW-1:0]  = per_c;
      A_PHOT:  bus_rdata[TW-1:0]  = per_h;
      default: ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == A_DATA + 8'(4*c)) bus_rdata[DW-1:0] = dat[c];
      if (bus_addr == A_ALC  + 8'(4*c)) bus_rdata[DW-1:0] = alc[c];
      if (bus_addr == A_SHC  + 8'(4*c)) bus_rdata[DW-1:0] = shc[c];
    end
  end

  // R2
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(adc_start));
  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) |adc_start |=> !(|adc_start));
  // R9
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !run |=> adc_start == '0);
  // R7
  gpio_latch_chk: assert property (@(posedge clk) disable iff (!rst_n) sh_g |=> sh_g);
  // R7
  rst_latch_chk: assert property (@(posedge clk) disable iff (!rst_n) sh_r |=> sh_r);
  // R5
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) |(pend & ~$past(pend)) |-> $past(take));
endmodule

// File: tb/tb_thermal_poll_ctrl.sv
module tb_thermal_poll_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [2:0]  adc_start, adc_done = '0;
  logic [35:0] adc_data = '0;
  logic        irq, shut_rst, shut_gpio;

  thermal_poll_ctrl dut (.*);

  always #5 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc++;

  int pass_n = 0, fail_n = 0;
  int alc_m[3] = '{0,0,0}, shc_m[3] = '{0,0,0}, acnt_m[3] = '{0,0,0}, scnt_m[3] = '{0,0,0};
  logic [2:0] pend_m = '0, hot_m = '0;
  int adeb_m = 10, sdeb_m = 10, pc_m = 1000, ph_m = 100, last_m = 2, t_done = 0;
  logic [11:0] ien_m = '0;
  bit pol_m = 0, shg_m = 0, shr_m = 0, gap_ok = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    if (ok) pass_n++;
    else begin fail_n++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
    case (a)
      8'h04: begin pol_m = d[8]; gap_ok = 0; end
      8'h08: ien_m = d[11:0];
      8'h0C: pend_m &= ~d[2:0];
      8'h60: adeb_m = int'(d[7:0]);
      8'h64: sdeb_m = int'(d[7:0]);
      8'h68: pc_m = int'(d[15:0]);
      8'h6C: ph_m = int'(d[15:0]);
      default: for (int c = 0; c < 3; c++) begin
        if (a == 8'h30 + 8'(4*c)) alc_m[c] = int'(d[11:0]);
        if (a == 8'h40 + 8'(4*c)) shc_m[c] = int'(d[11:0]);
      end
    endcase
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  function automatic int next_ch();
    logic [2:0] en = ien_m[2:0] | ien_m[6:4] | ien_m[10:8];
    for (int i = 1; i <= 3; i++) if (en[(last_m + i) % 3]) return (last_m + i) % 3;
    return -1;
  endfunction

  function automatic bit pin_lvl(bit act);
    return pol_m ? act : !act;
  endfunction

  task automatic serve(int code);
    int n = 0, ch = -1, ex;
    logic [31:0] r;
    while (adc_start == 3'b000 && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) begin chk(0, "R2 no start", 0, 1); return; end
    for (int c = 0; c < 3; c++) if (adc_start[c]) ch = c;
    chk($countones(adc_start) == 1, "R2 onehot", int'(adc_start), 1);
    ex = next_ch();
    chk(ch == ex, "R2 order", ch, ex);
    if (gap_ok) begin
      ex = (|hot_m ? ph_m : pc_m) + 1;
      chk(cyc - t_done == ex, "R4 interval", cyc - t_done, ex);
    end
    last_m = ch;
    @(negedge clk); @(negedge clk);
    adc_done[ch] = 1'b1; adc_data[ch*12 +: 12] = 12'(code); t_done = cyc; gap_ok = 1;
    @(negedge clk); adc_done = '0;
    if (code < alc_m[ch]) begin
      acnt_m[ch] = acnt_m[ch] < 255 ? acnt_m[ch] + 1 : 255;
      if (acnt_m[ch] >= adeb_m) pend_m[ch] = 1'b1;
    end else acnt_m[ch] = 0;
    if (code < shc_m[ch]) begin
      scnt_m[ch] = scnt_m[ch] < 255 ? scnt_m[ch] + 1 : 255;
      if (scnt_m[ch] >= sdeb_m) begin
        if (ien_m[4+ch]) shg_m = 1;
        if (ien_m[8+ch]) shr_m = 1;
      end
    end else scnt_m[ch] = 0;
    hot_m[ch] = (code < alc_m[ch]) || (code < shc_m[ch]);
    rd(8'h20 + 8'(4*ch), r);
    chk(r[11:0] == 12'(code), "R3 data", int'(r[11:0]), code);
    rd(8'h0C, r);
    chk(r[2:0] == pend_m, "R5 pending", int'(r[2:0]), int'(pend_m));
    chk(irq == |(pend_m & ien_m[2:0]), "R6 irq", int'(irq), int'(|(pend_m & ien_m[2:0])));
    chk(shut_gpio == pin_lvl(shg_m), "R7 gpio pin", int'(shut_gpio), int'(pin_lvl(shg_m)));
    chk(shut_rst == pin_lvl(shr_m), "R7 reset pin", int'(shut_rst), int'(pin_lvl(shr_m)));
  endtask

  initial begin
    #1_500_000;
    fail_n++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int starts;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h04, r); chk(r == 0, "R1 control", int'(r), 0);
    rd(8'h60, r); chk(r == 10, "R1 alarm count", int'(r), 10);
    rd(8'h64, r); chk(r == 10, "R1 shut count", int'(r), 10);
    rd(8'h68, r); chk(r == 1000, "R1 cool interval", int'(r), 1000);
    rd(8'h6C, r); chk(r == 100, "R1 hot interval", int'(r), 100);
    chk(irq == 0, "R1 irq", int'(irq), 0);
    chk(shut_gpio == 1 && shut_rst == 1, "R1 R8 idle pins", int'({shut_gpio, shut_rst}), 3);

    // directed: order, capture, intervals, alarm filter
    wr(8'h68, 20); wr(8'h6C, 8); wr(8'h30, 1000); wr(8'h38, 1000); wr(8'h60, 2);
    wr(8'h08, 32'h5); wr(8'h04, 32'h1);
    serve(3000); serve(3000); serve(500); serve(3000); serve(500);
    chk(irq == 1, "R5 R6 alarm after filter", int'(irq), 1);
    serve(3000);
    wr(8'h0C, 32'h1);
    rd(8'h0C, r); chk(r[2:0] == 0, "R6 clear", int'(r[2:0]), 0);
    chk(irq == 0, "R6 irq after clear", int'(irq), 0);
    serve(3000); serve(3000); serve(500);
    // routed-only channel: polled, interrupt masked
    wr(8'h08, 32'h010);
    serve(500);
    chk(irq == 0, "R6 masked", int'(irq), 0);

    // R9 stop keeps state
    wr(8'h04, 32'h0);
    starts = 0;
    repeat (300) begin @(negedge clk); if (adc_start != 0) starts++; end
    chk(starts == 0, "R9 no starts", starts, 0);
    rd(8'h20, r); chk(r[11:0] == 500, "R9 data kept", int'(r[11:0]), 500);
    rd(8'h0C, r); chk(r[2:0] == 3'b001, "R9 pending kept", int'(r[2:0]), 1);

    // constrained random around the alarm limit
    wr(8'h08, 32'h7); wr(8'h30, 2000); wr(8'h34, 2000); wr(8'h38, 2000);
    wr(8'h60, 3); wr(8'h68, 30); wr(8'h6C, 10); wr(8'h0C, 32'h7); wr(8'h04, 32'h1);
    for (int k = 0; k < 150; k++) begin
      serve(1900 + int'($urandom % 200));
      if ($urandom % 4 == 0) wr(8'h0C, $urandom % 8);
    end

    // shutdown latch, routing and polarity
    wr(8'h04, 32'h0); wr(8'h40, 1000); wr(8'h64, 2); wr(8'h08, 32'h010);
    wr(8'h04, 32'h101);
    chk(shut_gpio == 0 && shut_rst == 0, "R8 high polarity idle", int'({shut_gpio, shut_rst}), 0);
    serve(500);
    serve(500);
    chk(shut_gpio == 1 && shut_rst == 0, "R7 routed to gpio only", int'({shut_gpio, shut_rst}), 2);
    serve(3000);
    chk(shut_gpio == 1, "R7 latched", int'(shut_gpio), 1);
    wr(8'h04, 32'h001);
    chk(shut_gpio == 0 && shut_rst == 1, "R8 low polarity", int'({shut_gpio, shut_rst}), 1);

    $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
    $finish;
  end
endmodule